// File: doc/BRIEF.md
# Branch Resolution Unit

This block settles the outcome of one 32-bit RISC branch per cycle. From decoded instruction fields and the relevant architectural registers it decides whether the branch is taken, computes the next fetch address, and produces the new count-register value with a write strobe. It handles three branch kinds. Unconditional branches use a wide immediate. Conditional branches use a short immediate. Conditional branches can also jump to the address held in the link or count register.

A five-bit control field sets the rules for conditional branches. One bit decides whether the count register is decremented and tested. Another picks which result of that count test passes. A third decides whether a condition-register bit is examined at all. A fourth gives the value that bit must hold. The branch is taken only when both tests pass. Immediates are scaled by four and sign-extended. A separate flag chooses between PC-relative and absolute addressing. A parameter picks between a registered result stage (one cycle of latency) and a purely combinational result.

Top module: `brcu_top`

## Requirements
- R1: With `br_kind` = 0 (unconditional), the branch is always taken. The target is the `li` field shifted left by two and sign-extended from bit 25. It is added to `pc` when `abs_addr` = 0 and used directly when `abs_addr` = 1. `ctr_we` is 0 and `ctr_next` equals `ctr`.
- R2: With `br_kind` = 1 (conditional, immediate), a taken branch targets the `bd` field shifted left by two and sign-extended from bit 15. It is added to `pc` when `abs_addr` = 0 and used directly when `abs_addr` = 1.
- R3: For a conditional kind (1 or 2) with `bo_ctl[2]` = 1, the count test passes, `ctr_next` equals `ctr` and `ctr_we` is 0.
- R4: For a conditional kind with `bo_ctl[2]` = 0, `ctr_next` = `ctr` − 1 (wrapping modulo 2^32) and `ctr_we` = 1. The count test passes on a nonzero result when `bo_ctl[1]` = 0, and on a zero result when `bo_ctl[1]` = 1.
- R5: With `bo_ctl[4]` = 1 the condition test passes. Otherwise it passes when bit (31 − `bi`) of `cr`, counted from the LSB, equals `bo_ctl[3]`. So `bi` = 0 selects the MSB.
- R6: A conditional branch is taken only when the count test and the condition test both pass.
- R7: With `br_kind` = 2 (conditional, register), a taken branch targets `lr` when `reg_sel` = 0, or the pre-decrement `ctr` when `reg_sel` = 1, with the two low bits forced to zero.
- R8: Whenever the branch is not taken, `next_pc` = `pc` + 4.
- R9: `br_kind` = 3 is reserved. It is not taken, `next_pc` = `pc` + 4, `ctr_we` = 0 and `ctr_next` = `ctr`.
- R10: With the registered stage (default), results appear at the outputs one clock after the inputs are sampled. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_kind | input | 2 | 0 unconditional, 1 conditional immediate, 2 conditional register, 3 reserved |
| bo_ctl | input | 4 | Branch control bits [4:1]: 4 skip condition, 3 wanted CR value, 2 skip count, 1 count passes on zero |
| bi | input | 5 | Condition-register bit selector (0 = MSB) |
| li | input | 24 | Unconditional immediate, in words |
| bd | input | 14 | Conditional immediate, in words |
| abs_addr | input | 1 | 1 = immediate is an absolute address |
| reg_sel | input | 1 | Register-target source: 0 link, 1 count |
| pc | input | 32 | Address of the branch |
| cr | input | 32 | Condition register |
| ctr | input | 32 | Count register |
| lr | input | 32 | Link register |
| taken | output | 1 | Branch taken |
| next_pc | output | 32 | Next fetch address |
| ctr_next | output | 32 | Updated count register value |
| ctr_we | output | 1 | High when the count register was decremented |

## Verification
The bench builds the block with its defaults: a 32-bit address and count path, a 32-bit condition register, 24- and 14-bit immediates, and the registered result stage. These widths put both sign-extension boundaries (bit 25 and bit 15) and the count wrap from zero to all ones within reach of directed cases. The 32-entry condition register lets the bench reach both ends of the reversed bit numbering. Random stimulus biases the count register toward 0, 1 and 2, so that the zero/nonzero outcome of the decrement flips often under every combination of control bits.

// File: rtl/brcu_pkg.sv
package brcu_pkg;

   typedef enum logic [1:0] {
      BR_UNCOND    = 2'd0,
      BR_COND_DISP = 2'd1,
      BR_COND_REG  = 2'd2,
      BR_RSVD      = 2'd3
   } br_kind_e;

   // instruction words are four bytes
   localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/brcu_sext.sv
// Word-scaled immediate: appends two zero bits, then sign-extends to OUT_W.
module brcu_sext #(
   parameter int FIELD_W = 24,
   parameter int OUT_W   = 32
) (
   input  logic [FIELD_W-1:0] field,
   output logic [OUT_W-1:0]   ext
);
   localparam int SCALED_W = FIELD_W + 2;
   localparam int PAD_W    = OUT_W - SCALED_W;

   if (FIELD_W < 1) begin : g_bad_field
      $error("brcu_sext: FIELD_W must be positive");
   end
   if (OUT_W < SCALED_W) begin : g_bad_out
      $error("brcu_sext: OUT_W too narrow for scaled field");
   end

   if (PAD_W == 0) begin : g_exact
      assign ext = {field, 2'b00};
   end else begin : g_pad
      assign ext = {{PAD_W{field[FIELD_W-1]}}, field, 2'b00};
   end
endmodule

// File: rtl/brcu_ctr_eval.sv
// Count-register decrement and zero test.
module brcu_ctr_eval #(
   parameter int CTR_W = 32
) (
   input  logic             active,     // conditional kind in flight
   input  logic             skip_ctr,   // control bit of weight 4
   input  logic             pass_zero,  // control bit of weight 2
   input  logic [CTR_W-1:0] ctr,
   output logic             ctr_ok,
   output logic [CTR_W-1:0] ctr_upd,
   output logic             ctr_dec
);
   logic [CTR_W-1:0] dec_val;
   logic             dec_zero;

   if (CTR_W < 2) begin : g_bad_w
      $error("brcu_ctr_eval: CTR_W must be at least 2");
   end

   assign dec_val  = ctr - CTR_W'(1);
   assign dec_zero = (dec_val == '0);

   always_comb begin
      ctr_dec = active & ~skip_ctr;
      ctr_upd = ctr_dec ? dec_val : ctr;
      if (skip_ctr) begin
         ctr_ok = 1'b1;
      end else if (pass_zero) begin
         ctr_ok = dec_zero;
      end else begin
         ctr_ok = ~dec_zero;
      end
   end
endmodule

// File: rtl/brcu_cr_eval.sv
// Condition-register bit test with MSB-first bit numbering.
module brcu_cr_eval #(
   parameter int CR_W = 32,
   localparam int SEL_W = $clog2(CR_W)
) (
   input  logic             skip_cond,  // control bit of weight 16
   input  logic             want_bit,   // control bit of weight 8
   input  logic [SEL_W-1:0] sel,
   input  logic [CR_W-1:0]  cr,
   output logic             cond_ok
);
   logic [CR_W-1:0] cr_msb_first;
   logic            picked;

   if (CR_W < 2 || (CR_W & (CR_W - 1)) != 0) begin : g_bad_cr
      $error("brcu_cr_eval: CR_W must be a power of two");
   end

   for (genvar i = 0; i < CR_W; i++) begin : g_rev
      assign cr_msb_first[i] = cr[CR_W-1-i];
   end

   assign picked  = cr_msb_first[sel];
   assign cond_ok = skip_cond | (picked == want_bit);
endmodule

// File: rtl/brcu_target.sv
// Next-address selection with one shared relative adder.
module brcu_target #(
   parameter int ADDR_W = 32
) (
   input  brcu_pkg::br_kind_e kind,
   input  logic               abs_addr,
   input  logic               reg_sel,
   input  logic               taken,
   input  logic [ADDR_W-1:0]  pc,
   input  logic [ADDR_W-1:0]  li_ext,
   input  logic [ADDR_W-1:0]  bd_ext,
   input  logic [ADDR_W-1:0]  lr,
   input  logic [ADDR_W-1:0]  ctr,
   output logic [ADDR_W-1:0]  next_addr
);
   import brcu_pkg::*;

   logic [ADDR_W-1:0] disp_sel;
   logic [ADDR_W-1:0] rel_sum;
   logic [ADDR_W-1:0] seq_addr;
   logic [ADDR_W-1:0] reg_src;
   logic [ADDR_W-1:0] imm_tgt;

   assign disp_sel = (kind == BR_UNCOND) ? li_ext : bd_ext;
   assign rel_sum  = pc + disp_sel;
   assign seq_addr = pc + ADDR_W'(INSN_BYTES);
   assign reg_src  = reg_sel ? ctr : lr;
   assign imm_tgt  = abs_addr ? disp_sel : rel_sum;

   always_comb begin
      next_addr = seq_addr;
      if (taken) begin
         unique case (kind)
            BR_UNCOND, BR_COND_DISP: next_addr = imm_tgt;
            BR_COND_REG:             next_addr = {reg_src[ADDR_W-1:2], 2'b00};
            default:                 next_addr = seq_addr;
         endcase
      end
   end
endmodule

// File: rtl/brcu_top.sv
module brcu_top #(
   parameter int XLEN    = 32,
   parameter int CR_W    = 32,
   parameter int LI_W    = 24,
   parameter int BD_W    = 14,
   parameter bit OUT_REG = 1'b1,
   localparam int SEL_W  = $clog2(CR_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       br_kind,
   input  logic [4:1]       bo_ctl,
   input  logic [SEL_W-1:0] bi,
   input  logic [LI_W-1:0]  li,
   input  logic [BD_W-1:0]  bd,
   input  logic             abs_addr,
   input  logic             reg_sel,
   input  logic [XLEN-1:0]  pc,
   input  logic [CR_W-1:0]  cr,
   input  logic [XLEN-1:0]  ctr,
   input  logic [XLEN-1:0]  lr,
   output logic             taken,
   output logic [XLEN-1:0]  next_pc,
   output logic [XLEN-1:0]  ctr_next,
   output logic             ctr_we
);
   import brcu_pkg::*;

   if (XLEN < LI_W + 2 || XLEN < BD_W + 2) begin : g_bad_xlen
      $error("brcu_top: XLEN narrower than a scaled immediate");
   end

   br_kind_e          kind;
   logic              is_cond;
   logic              ctr_ok, cond_ok, taken_c, dec_c;
   logic [XLEN-1:0]   li_ext, bd_ext, ctr_upd, next_c;

   assign kind    = br_kind_e'(br_kind);
   assign is_cond = (kind == BR_COND_DISP) || (kind == BR_COND_REG);

   brcu_sext #(.FIELD_W(LI_W), .OUT_W(XLEN)) u_li_ext (.field(li), .ext(li_ext));
   brcu_sext #(.FIELD_W(BD_W), .OUT_W(XLEN)) u_bd_ext (.field(bd), .ext(bd_ext));

   brcu_ctr_eval #(.CTR_W(XLEN)) u_ctr (
      .active   (is_cond),
      .skip_ctr (bo_ctl[2]),
      .pass_zero(bo_ctl[1]),
      .ctr      (ctr),
      .ctr_ok   (ctr_ok),
      .ctr_upd  (ctr_upd),
      .ctr_dec  (dec_c)
   );

   brcu_cr_eval #(.CR_W(CR_W)) u_cr (
      .skip_cond(bo_ctl[4]),
      .want_bit (bo_ctl[3]),
      .sel      (bi),
      .cr       (cr),
      .cond_ok  (cond_ok)
   );

   always_comb begin
      unique case (kind)
         BR_UNCOND:                taken_c = 1'b1;
         BR_COND_DISP, BR_COND_REG: taken_c = ctr_ok & cond_ok;
         default:                  taken_c = 1'b0;
      endcase
   end

   brcu_target #(.ADDR_W(XLEN)) u_tgt (
      .kind     (kind),
      .abs_addr (abs_addr),
      .reg_sel  (reg_sel),
      .taken    (taken_c),
      .pc       (pc),
      .li_ext   (li_ext),
      .bd_ext   (bd_ext),
      .lr       (lr),
      .ctr      (ctr),
      .next_addr(next_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            taken    <= 1'b0;
            next_pc  <= '0;
            ctr_next <= '0;
            ctr_we   <= 1'b0;
         end else begin
            taken    <= taken_c;
            next_pc  <= next_c;
            ctr_next <= ctr_upd;
            ctr_we   <= dec_c;
         end
      end
   end else begin : g_comb
      assign taken    = taken_c;
      assign next_pc  = next_c;
      assign ctr_next = ctr_upd;
      assign ctr_we   = dec_c;
   end

   // R3
   ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bo_ctl[2] |-> (!dec_c && ctr_upd == ctr));

   // R4
   ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_c |-> (ctr_upd == ctr - XLEN'(1)));

   // R6
   both_tests_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_c && is_cond) |-> (ctr_ok && cond_ok));

   // R7
   reg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_c && kind == BR_COND_REG) |-> (next_c[1:0] == 2'b00));

   // R8
   fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !taken_c |-> (next_c == pc + XLEN'(4)));

   // R9
   rsvd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == BR_RSVD) |-> (!taken_c && !dec_c));

   if (OUT_REG) begin : g_lat_chk
      // R10
      we_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ctr_we |-> ($past(is_cond) && !$past(bo_ctl[2])));
   end
endmodule

// File: tb/sim_brcu_top.sv
module sim_brcu_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  br_kind = '0;
   logic [4:1]  bo_ctl = '0;
   logic [4:0]  bi = '0;
   logic [23:0] li = '0;
   logic [13:0] bd = '0;
   logic        abs_addr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] pc = '0, cr = '0, ctr = '0, lr = '0;
   logic        taken, ctr_we;
   logic [31:0] next_pc, ctr_next;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   brcu_top u0 (
      .clk(clk), .rst_n(rst_n), .br_kind(br_kind), .bo_ctl(bo_ctl), .bi(bi),
      .li(li), .bd(bd), .abs_addr(abs_addr), .reg_sel(reg_sel), .pc(pc),
      .cr(cr), .ctr(ctr), .lr(lr), .taken(taken), .next_pc(next_pc),
      .ctr_next(ctr_next), .ctr_we(ctr_we)
   );

   function automatic void model(
      output logic        e_t,
      output logic [31:0] e_nx,
      output logic [31:0] e_cn,
      output logic        e_we);
      logic [31:0] d;
      logic        kok, cok;
      e_t = 1'b0; e_we = 1'b0; e_cn = ctr; e_nx = pc + 32'd4;
      if (br_kind == 2'd0) begin
         d = {6'b0, li, 2'b00};
         if (d[25]) d = d | 32'hFC00_0000;
         e_t  = 1'b1;
         e_nx = abs_addr ? d : pc + d;
      end else if (br_kind == 2'd1 || br_kind == 2'd2) begin
         kok = 1'b1;
         if (!bo_ctl[2]) begin
            e_cn = ctr - 32'd1;
            e_we = 1'b1;
            kok  = bo_ctl[1] ? (e_cn == 0) : (e_cn != 0);
         end
         cok = bo_ctl[4] ? 1'b1 : (((cr >> (31 - bi)) & 32'd1) == {31'd0, bo_ctl[3]});
         e_t = kok && cok;
         if (e_t) begin
            if (br_kind == 2'd1) begin
               d = {16'b0, bd, 2'b00};
               if (d[15]) d = d | 32'hFFFF_0000;
               e_nx = abs_addr ? d : pc + d;
            end else begin
               e_nx = (reg_sel ? ctr : lr) & ~32'd3;
            end
         end
      end
   endfunction

   task automatic compare(input string tag, input logic e_t, input logic [31:0] e_nx,
                          input logic [31:0] e_cn, input logic e_we);
      checks++;
      if (taken !== e_t || next_pc !== e_nx || ctr_next !== e_cn || ctr_we !== e_we) begin
         fails++;
         $display("FAIL %s: taken=%0b next_pc=%h ctr_next=%h ctr_we=%0b, expected taken=%0b next_pc=%h ctr_next=%h ctr_we=%0b",
                  tag, taken, next_pc, ctr_next, ctr_we, e_t, e_nx, e_cn, e_we);
      end
   endtask

   // drive after an edge, let one edge register, sample 1 ns later
   task automatic run(input string tag, input logic [1:0] k, input logic [4:1] b,
                      input logic [4:0] sel, input logic [23:0] l, input logic [13:0] dd,
                      input logic ab, input logic rs, input logic [31:0] p,
                      input logic [31:0] c, input logic [31:0] cnt, input logic [31:0] lnk);
      logic        e_t, e_we;
      logic [31:0] e_nx, e_cn;
      br_kind = k; bo_ctl = b; bi = sel; li = l; bd = dd; abs_addr = ab;
      reg_sel = rs; pc = p; cr = c; ctr = cnt; lr = lnk;
      model(e_t, e_nx, e_cn, e_we);
      @(posedge clk);
      #1;
      compare(tag, e_t, e_nx, e_cn, e_we);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd1234);
      repeat (3) @(posedge clk);
      #1;
      // R10: reset clears outputs
      compare("R10 reset", 1'b0, 32'd0, 32'd0, 1'b0);
      rst_n = 1'b1;

      // R1: unconditional, positive relative, negative relative, negative absolute
      run("R1 rel pos", 2'd0, 4'b0000, 5'd0, 24'h000010, 14'd0, 1'b0, 1'b0, 32'h1000, 32'd0, 32'h55, 32'd0);
      run("R1 rel neg", 2'd0, 4'b0000, 5'd0, 24'hFFFFFF, 14'd0, 1'b0, 1'b0, 32'h1000, 32'd0, 32'h55, 32'd0);
      run("R1 abs neg", 2'd0, 4'b0000, 5'd0, 24'h800000, 14'd0, 1'b1, 1'b0, 32'h1000, 32'd0, 32'h55, 32'd0);
      // R2 with R3: conditions skipped, negative relative and negative absolute
      run("R2 rel neg", 2'd1, 4'b1010, 5'd0, 24'd0, 14'h3FFF, 1'b0, 1'b0, 32'h2000, 32'd0, 32'h7, 32'd0);
      run("R2 abs neg", 2'd1, 4'b1010, 5'd0, 24'd0, 14'h2000, 1'b1, 1'b0, 32'h2000, 32'd0, 32'h7, 32'd0);
      // R4: decrement to zero, pass on zero / fail on nonzero sense
      run("R4 zero pass", 2'd1, 4'b1001, 5'd0, 24'd0, 14'h0004, 1'b0, 1'b0, 32'h3000, 32'd0, 32'd1, 32'd0);
      run("R4 R8 zero fail", 2'd1, 4'b1000, 5'd0, 24'd0, 14'h0004, 1'b0, 1'b0, 32'h3000, 32'd0, 32'd1, 32'd0);
      run("R4 wrap", 2'd1, 4'b1000, 5'd0, 24'd0, 14'h0004, 1'b0, 1'b0, 32'h3000, 32'd0, 32'd0, 32'd0);
      // R5: MSB selected by bi=0, LSB by bi=31
      run("R5 msb", 2'd1, 4'b0110, 5'd0, 24'd0, 14'h0008, 1'b0, 1'b0, 32'h4000, 32'h8000_0000, 32'd9, 32'd0);
      run("R5 lsb", 2'd1, 4'b0010, 5'd31, 24'd0, 14'h0008, 1'b0, 1'b0, 32'h4000, 32'h0000_0001, 32'd9, 32'd0);
      // R6: count passes, condition fails
      run("R6 cond fail", 2'd1, 4'b0100, 5'd3, 24'd0, 14'h0008, 1'b0, 1'b0, 32'h4000, 32'h0000_0000, 32'd5, 32'd0);
      // R7: register targets, aligned, count source before decrement
      run("R7 lr", 2'd2, 4'b1010, 5'd0, 24'd0, 14'd0, 1'b0, 1'b0, 32'h5000, 32'd0, 32'd3, 32'h1234_5677);
      run("R7 ctr", 2'd2, 4'b1000, 5'd0, 24'd0, 14'd0, 1'b0, 1'b1, 32'h5000, 32'd0, 32'h0000_2003, 32'h1234_5677);
      // R9: reserved kind
      run("R9 rsvd", 2'd3, 4'b0000, 5'd0, 24'h000100, 14'h0100, 1'b0, 1'b1, 32'h6000, 32'hFFFF_FFFF, 32'd1, 32'hABCD);

      // random mix, count register biased toward the zero boundary
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] rc;
         rc = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 2)) : $urandom;
         run("R1-mix random R2 R4 R5 R6 R7 R8 R9", 2'($urandom), 4'($urandom), 5'($urandom),
             24'($urandom), 14'($urandom), 1'($urandom), 1'($urandom),
             $urandom, $urandom, rc, $urandom);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule